// File: doc/BRIEF.md
# I2C Slave Transmit Flow Controller

This block runs the data-sending side of an I2C slave after the address stage has matched a read request. Software writes bytes into a one-byte holding register. The block moves each byte into a shift register, which a bit engine clocks out most significant bit first. The block holds SCL low whenever no byte is ready: first until the address flag has been acknowledged by software, and later whenever the master has acknowledged a byte and no replacement has been written.

It keeps four status flags: address-seen, holding-register-empty, byte-finished and no-acknowledge. It combines them into one event interrupt under two enables. The address flag and the byte-finished flag are cleared by access sequences rather than by a plain clear bit. After a NACK the block lets go of the bus lines and waits for the bus to end the transfer before it goes idle.

Top module: `slv_tx_flow`

## Requirements
- R1: A pulse on `addrMatch` while idle sets `addrFlag` and `txEmpty` and raises `sclHold`. `sclHold` stays high until `addrFlag` is clear and a written byte has moved into the shift register, even if the byte was written while `addrFlag` was set.
- R2: `addrFlag` clears only on a `stat2Rd` pulse that comes after a `stat1Rd` pulse. A `stat2Rd` with no earlier `stat1Rd` leaves it set.
- R3: A `dataWr` pulse during an active transfer clears `txEmpty`. When the shift register is empty and `addrFlag` is clear, the byte moves into the shift register on the next clock. That move sets `txEmpty` and drops `sclHold`.
- R4: `evIrq` equals `evIntEn` AND (`addrFlag` OR `btfFlag` OR `ackFail` OR (`bufIntEn` AND `txEmpty`)).
- R5: An ACK (`ackStrobe` with `ackNack`=0 after the eighth bit) with no byte written since the last move sets `btfFlag`, and `sclHold` stays high until a write. If a byte was written beforehand, `btfFlag` stays clear and the byte moves one clock after the ACK.
- R6: `btfFlag` clears only on a `dataWr` that follows a `stat1Rd` made while it was set. A write with no such read leaves it set.
- R7: `sdaOut` presents the loaded byte most significant bit first, one new bit per `bitShift` pulse. It is 1 in the acknowledge slot and whenever no byte is being sent.
- R8: A NACK (`ackStrobe` with `ackNack`=1 after the eighth bit) sets `ackFail`. Only an `ackFailClr` pulse clears it.
- R9: After a NACK, `sclHold` is low and `sdaOut` is 1. `dataWr` and `bitShift` have no effect. A `busEnd` pulse returns the block to idle with `txEmpty`, `btfFlag` and `addrFlag` clear.
- R10: While idle, `dataWr` is ignored. It leaves `txEmpty` at 0, and a later session starts with an empty holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrMatch | input | 1 | Pulse: address matched for a read |
| stat1Rd | input | 1 | Pulse: first status register read |
| stat2Rd | input | 1 | Pulse: second status register read |
| dataWr | input | 1 | Pulse: holding register write |
| dataIn | input | DATA_W | Byte written with `dataWr` |
| ackFailClr | input | 1 | Pulse: software clears `ackFail` |
| evIntEn | input | 1 | Event interrupt enable |
| bufIntEn | input | 1 | Buffer interrupt enable |
| bitShift | input | 1 | Pulse from bit engine: advance to next bit |
| ackStrobe | input | 1 | Pulse: master acknowledge bit sampled |
| ackNack | input | 1 | Sampled acknowledge bit, 1 = NACK |
| busEnd | input | 1 | Pulse: stop or repeated start seen |
| sclHold | output | 1 | Hold SCL low |
| sdaOut | output | 1 | SDA drive value (1 = released) |
| addrFlag | output | 1 | Address-seen flag |
| txEmpty | output | 1 | Holding register empty flag |
| btfFlag | output | 1 | Byte-finished flag |
| ackFail | output | 1 | No-acknowledge flag |
| evIrq | output | 1 | Event interrupt |

## Verification
The hardest case to reach is a full byte-finished episode. The master must acknowledge a byte while the holding register is still empty. Software must then write once without a status read, which leaves the flag set. Only after that does a read followed by a second write clear it. The bench builds this inside one continuous session: the stray write becomes the next transmitted byte, and the clearing write becomes the byte after it. The same session then checks that a byte prepared ahead of the ACK moves across with no flag and only a one-clock stretch.

// File: rtl/slv_tx_pkg.sv
package slv_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_NACK   = 2'd2
  } txState_t;

  typedef struct packed {
    logic drWrite;
    logic shLoad;
    logic shShift;
    logic shDrop;
  } dpStrb_t;

endpackage

// File: rtl/slv_tx_dpath.sv
module slv_tx_dpath
  import slv_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              shEmpty,
  output logic              bitsDone,
  output logic              sdaBit
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              shLoaded;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strb.drWrite) begin
      dataReg <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      shLoaded <= 1'b0;
    end else if (strb.shDrop) begin
      shLoaded <= 1'b0;
      bitCnt   <= '0;
    end else if (strb.shLoad) begin
      shReg    <= dataReg;
      shLoaded <= 1'b1;
      bitCnt   <= '0;
    end else if (strb.shShift) begin
      shReg  <= {shReg[DATA_W-2:0], 1'b0};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign shEmpty  = !shLoaded;
  assign bitsDone = (bitCnt == LAST_CNT);
  assign sdaBit   = (shLoaded && !bitsDone) ? shReg[DATA_W-1] : 1'b1;

  // R3: a byte is only moved into an empty shift register
  p_load_into_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.shLoad |-> !shLoaded);

  // R7: shifting only happens inside a loaded byte
  p_shift_in_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.shShift |-> (shLoaded && bitCnt < LAST_CNT));

endmodule

// File: rtl/slv_tx_ctrl.sv
module slv_tx_ctrl
  import slv_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    addrMatch,
  input  logic    stat1Rd,
  input  logic    stat2Rd,
  input  logic    dataWr,
  input  logic    ackFailClr,
  input  logic    evIntEn,
  input  logic    bufIntEn,
  input  logic    bitShift,
  input  logic    ackStrobe,
  input  logic    ackNack,
  input  logic    busEnd,
  input  logic    shEmpty,
  input  logic    bitsDone,
  output dpStrb_t strb,
  output logic    sclHold,
  output logic    addrFlag,
  output logic    txEmpty,
  output logic    btfFlag,
  output logic    ackFail,
  output logic    evIrq
);

  txState_t state;
  logic     drFull;
  logic     sr1Seen;
  logic     btfRdSeen;

  logic active;
  logic loadNow;
  logic ackEv;
  logic goodAck;
  logic badAck;

  assign active  = (state == ST_ACTIVE);
  assign loadNow = active && !busEnd && !addrFlag && drFull && shEmpty;
  assign ackEv   = active && !busEnd && ackStrobe && bitsDone && !shEmpty;
  assign goodAck = ackEv && !ackNack;
  assign badAck  = ackEv && ackNack;

  always_comb begin
    strb.drWrite = active && !busEnd && dataWr;
    strb.shLoad  = loadNow;
    strb.shShift = active && !busEnd && bitShift && !shEmpty && !bitsDone;
    strb.shDrop  = ackEv || (busEnd && state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      addrFlag  <= 1'b0;
      txEmpty   <= 1'b0;
      btfFlag   <= 1'b0;
      ackFail   <= 1'b0;
      drFull    <= 1'b0;
      sr1Seen   <= 1'b0;
      btfRdSeen <= 1'b0;
    end else begin
      if (ackFailClr) ackFail <= 1'b0;
      if (badAck)     ackFail <= 1'b1;

      if (stat1Rd) sr1Seen <= 1'b1;
      if (stat2Rd) sr1Seen <= 1'b0;
      if (stat2Rd && sr1Seen) addrFlag <= 1'b0;
      if (stat1Rd && btfFlag) btfRdSeen <= 1'b1;

      case (state)
        ST_IDLE: begin
          if (addrMatch) begin
            state     <= ST_ACTIVE;
            addrFlag  <= 1'b1;
            txEmpty   <= 1'b1;
            drFull    <= 1'b0;
            btfFlag   <= 1'b0;
            btfRdSeen <= 1'b0;
            sr1Seen   <= 1'b0;
          end
        end
        ST_ACTIVE: begin
          if (busEnd) begin
            state     <= ST_IDLE;
            addrFlag  <= 1'b0;
            txEmpty   <= 1'b0;
            drFull    <= 1'b0;
            btfFlag   <= 1'b0;
            btfRdSeen <= 1'b0;
          end else begin
            if (loadNow) begin
              drFull  <= 1'b0;
              txEmpty <= 1'b1;
            end
            if (goodAck && !drFull) btfFlag <= 1'b1;
            if (badAck) state <= ST_NACK;
            if (dataWr) begin
              drFull  <= 1'b1;
              txEmpty <= 1'b0;
              if (btfRdSeen) begin
                btfFlag   <= 1'b0;
                btfRdSeen <= 1'b0;
              end
            end
          end
        end
        ST_NACK: begin
          if (busEnd) begin
            state     <= ST_IDLE;
            addrFlag  <= 1'b0;
            txEmpty   <= 1'b0;
            drFull    <= 1'b0;
            btfFlag   <= 1'b0;
            btfRdSeen <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclHold = active && (addrFlag || shEmpty);
  assign evIrq   = evIntEn && (addrFlag || btfFlag || ackFail || (bufIntEn && txEmpty));

  // R2: the address flag falls only on the second status read (or bus end)
  p_addr_clear_seq_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrFlag) |-> ($past(stat2Rd) || $past(busEnd)));

  // R3: empty flag falls only on a data write (or bus end)
  p_txe_fall_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> ($past(dataWr) || $past(busEnd)));

  // R5: byte-finished only rises while the holding register is empty
  p_btf_after_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(btfFlag) |-> $past(txEmpty));

  // R8: no-acknowledge flag falls only on the software clear
  p_af_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackFail) |-> $past(ackFailClr));

  // R9: once in the NACK wait, no new byte is loaded
  p_nack_no_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NACK) |=> !(state == ST_ACTIVE && $past(state) == ST_NACK));

endmodule

// File: rtl/slv_tx_flow.sv
module slv_tx_flow
  import slv_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrMatch,
  input  logic              stat1Rd,
  input  logic              stat2Rd,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ackFailClr,
  input  logic              evIntEn,
  input  logic              bufIntEn,
  input  logic              bitShift,
  input  logic              ackStrobe,
  input  logic              ackNack,
  input  logic              busEnd,
  output logic              sclHold,
  output logic              sdaOut,
  output logic              addrFlag,
  output logic              txEmpty,
  output logic              btfFlag,
  output logic              ackFail,
  output logic              evIrq
);

  dpStrb_t strb;
  logic    shEmpty;
  logic    bitsDone;

  slv_tx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrMatch  (addrMatch),
    .stat1Rd    (stat1Rd),
    .stat2Rd    (stat2Rd),
    .dataWr     (dataWr),
    .ackFailClr (ackFailClr),
    .evIntEn    (evIntEn),
    .bufIntEn   (bufIntEn),
    .bitShift   (bitShift),
    .ackStrobe  (ackStrobe),
    .ackNack    (ackNack),
    .busEnd     (busEnd),
    .shEmpty    (shEmpty),
    .bitsDone   (bitsDone),
    .strb       (strb),
    .sclHold    (sclHold),
    .addrFlag   (addrFlag),
    .txEmpty    (txEmpty),
    .btfFlag    (btfFlag),
    .ackFail    (ackFail),
    .evIrq      (evIrq)
  );

  slv_tx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataIn   (dataIn),
    .shEmpty  (shEmpty),
    .bitsDone (bitsDone),
    .sdaBit   (sdaOut)
  );

endmodule

// File: tb/slv_tx_flow_bench.sv
`timescale 1ns/1ps
module slv_tx_flow_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrMatch = 1'b0, stat1Rd = 1'b0, stat2Rd = 1'b0, dataWr = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       ackFailClr = 1'b0, evIntEn = 1'b0, bufIntEn = 1'b0;
  logic       bitShift = 1'b0, ackStrobe = 1'b0, ackNack = 1'b0, busEnd = 1'b0;
  logic       sclHold, sdaOut, addrFlag, txEmpty, btfFlag, ackFail, evIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  slv_tx_flow u_slv_tx_flow (
    .clk(clk), .rstN(rstN), .addrMatch(addrMatch), .stat1Rd(stat1Rd),
    .stat2Rd(stat2Rd), .dataWr(dataWr), .dataIn(dataIn), .ackFailClr(ackFailClr),
    .evIntEn(evIntEn), .bufIntEn(bufIntEn), .bitShift(bitShift),
    .ackStrobe(ackStrobe), .ackNack(ackNack), .busEnd(busEnd),
    .sclHold(sclHold), .sdaOut(sdaOut), .addrFlag(addrFlag), .txEmpty(txEmpty),
    .btfFlag(btfFlag), .ackFail(ackFail), .evIrq(evIrq)
  );

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulseAddr();
    @(negedge clk); addrMatch = 1'b1; @(negedge clk); addrMatch = 1'b0; #1;
  endtask
  task automatic pulseS1();
    @(negedge clk); stat1Rd = 1'b1; @(negedge clk); stat1Rd = 1'b0; #1;
  endtask
  task automatic pulseS2();
    @(negedge clk); stat2Rd = 1'b1; @(negedge clk); stat2Rd = 1'b0; #1;
  endtask
  task automatic pulseWr(input logic [7:0] v);
    @(negedge clk); dataIn = v; dataWr = 1'b1; @(negedge clk); dataWr = 1'b0; #1;
  endtask
  task automatic pulseShift();
    @(negedge clk); bitShift = 1'b1; @(negedge clk); bitShift = 1'b0; #1;
  endtask
  task automatic pulseAck(input logic nack);
    @(negedge clk); ackNack = nack; ackStrobe = 1'b1;
    @(negedge clk); ackStrobe = 1'b0; ackNack = 1'b0; #1;
  endtask
  task automatic pulseAfClr();
    @(negedge clk); ackFailClr = 1'b1; @(negedge clk); ackFailClr = 1'b0; #1;
  endtask
  task automatic pulseEnd();
    @(negedge clk); busEnd = 1'b1; @(negedge clk); busEnd = 1'b0; #1;
  endtask

  // Shifts a byte out, checking each bit MSB first; optional mid-byte write
  task automatic sendByte(input logic [7:0] v, input bit midWr, input logic [7:0] nextV);
    for (int i = 7; i >= 0; i--) begin
      check("R7 sda bit", {7'd0, sdaOut}, {7'd0, v[i]});
      if (midWr && i == 4) pulseWr(nextV);
      pulseShift();
    end
    check("R7 sda released in ack slot", {7'd0, sdaOut}, 8'd1);
  endtask

  task automatic testReset();
    tick(3);
    rstN = 1'b1;
    tick(1);
    check("R1 reset sclHold", {7'd0, sclHold}, 8'd0);
    check("R1 reset addrFlag", {7'd0, addrFlag}, 8'd0);
    check("R3 reset txEmpty", {7'd0, txEmpty}, 8'd0);
    check("R7 reset sdaOut", {7'd0, sdaOut}, 8'd1);
    check("R4 reset evIrq", {7'd0, evIrq}, 8'd0);
  endtask

  task automatic testAddrPhase();
    evIntEn = 1'b1;
    pulseAddr();
    check("R1 addrFlag set", {7'd0, addrFlag}, 8'd1);
    check("R1 txEmpty set", {7'd0, txEmpty}, 8'd1);
    check("R1 sclHold high", {7'd0, sclHold}, 8'd1);
    check("R4 irq from addrFlag", {7'd0, evIrq}, 8'd1);
    pulseWr(8'hA5);
    check("R3 txEmpty cleared by write", {7'd0, txEmpty}, 8'd0);
    tick(1);
    check("R1 hold kept while addrFlag set", {7'd0, sclHold}, 8'd1);
    pulseS2();
    check("R2 stat2 alone keeps addrFlag", {7'd0, addrFlag}, 8'd1);
    pulseS1();
    check("R2 stat1 alone keeps addrFlag", {7'd0, addrFlag}, 8'd1);
    pulseS2();
    check("R2 stat1 then stat2 clears addrFlag", {7'd0, addrFlag}, 8'd0);
    check("R1 hold until byte moved", {7'd0, sclHold}, 8'd1);
    tick(1);
    check("R3 hold released after move", {7'd0, sclHold}, 8'd0);
    check("R3 txEmpty set after move", {7'd0, txEmpty}, 8'd1);
    check("R4 irq off without buffer enable", {7'd0, evIrq}, 8'd0);
    bufIntEn = 1'b1; #1;
    check("R4 irq with buffer enable", {7'd0, evIrq}, 8'd1);
    bufIntEn = 1'b0; #1;
  endtask

  task automatic testBtf();
    sendByte(8'hA5, 1'b0, 8'h00);
    pulseAck(1'b0);
    check("R5 btf set on ack with empty register", {7'd0, btfFlag}, 8'd1);
    check("R5 hold after ack", {7'd0, sclHold}, 8'd1);
    tick(2);
    check("R5 hold kept until write", {7'd0, sclHold}, 8'd1);
    check("R4 irq from btf", {7'd0, evIrq}, 8'd1);
    pulseWr(8'h3C);
    check("R6 write without read keeps btf", {7'd0, btfFlag}, 8'd1);
    pulseS1();
    check("R5 hold released by write", {7'd0, sclHold}, 8'd0);
    pulseWr(8'h96);
    check("R6 write after read clears btf", {7'd0, btfFlag}, 8'd0);
    check("R3 register full", {7'd0, txEmpty}, 8'd0);
  endtask

  task automatic testPrewrite();
    sendByte(8'h3C, 1'b0, 8'h00);
    pulseAck(1'b0);
    check("R5 no btf when byte prepared", {7'd0, btfFlag}, 8'd0);
    check("R5 one-clock hold at ack", {7'd0, sclHold}, 8'd1);
    tick(1);
    check("R5 prepared byte moved", {7'd0, sclHold}, 8'd0);
    check("R3 txEmpty after move", {7'd0, txEmpty}, 8'd1);
  endtask

  task automatic testNack();
    sendByte(8'h96, 1'b0, 8'h00);
    pulseAck(1'b1);
    check("R8 ackFail set on nack", {7'd0, ackFail}, 8'd1);
    check("R9 hold released after nack", {7'd0, sclHold}, 8'd0);
    check("R9 sda released after nack", {7'd0, sdaOut}, 8'd1);
    check("R4 irq from ackFail", {7'd0, evIrq}, 8'd1);
    pulseWr(8'h00);
    check("R9 write ignored after nack", {7'd0, txEmpty}, 8'd1);
    tick(1);
    check("R9 no reload after nack", {7'd0, sclHold}, 8'd0);
    pulseShift();
    check("R9 shift ignored after nack", {7'd0, sdaOut}, 8'd1);
    pulseAfClr();
    check("R8 ackFail cleared", {7'd0, ackFail}, 8'd0);
    pulseEnd();
    check("R9 idle txEmpty clear", {7'd0, txEmpty}, 8'd0);
    check("R9 idle btf clear", {7'd0, btfFlag}, 8'd0);
    check("R9 idle addrFlag clear", {7'd0, addrFlag}, 8'd0);
  endtask

  task automatic testIdleWrite();
    pulseWr(8'h55);
    check("R10 idle write keeps txEmpty low", {7'd0, txEmpty}, 8'd0);
    check("R10 idle no hold", {7'd0, sclHold}, 8'd0);
    pulseAddr();
    pulseS1();
    pulseS2();
    tick(2);
    check("R10 new session register empty", {7'd0, sclHold}, 8'd1);
    check("R10 new session txEmpty", {7'd0, txEmpty}, 8'd1);
    pulseWr(8'hC3);
    tick(1);
    check("R3 new session byte moved", {7'd0, sclHold}, 8'd0);
    check("R7 new session first bit", {7'd0, sdaOut}, 8'd1);
  endtask

  initial begin
    testReset();
    testAddrPhase();
    testBtf();
    testPrewrite();
    testNack();
    testIdleWrite();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule